// File: doc/BRIEF.md
# Coprocessor Decrement-and-Branch Controller

This block sequences the main-processor side of a loop instruction whose exit test is evaluated by a coprocessor. A start pulse hands it four things: the data-register index taken from bits 2–0 of the operation word, the condition-selector word, the 16-bit displacement word, and the scan PC. The scan PC must be the address of the displacement word. Any coprocessor-defined extension words ahead of the displacement are fetched elsewhere and never reach this block.

The controller writes the selector to the coprocessor's condition register. It then polls the response register once per cycle. A "busy" response makes it poll again, up to a programmable number of times. A "true" response ends the instruction with no register change. A "false" response decrements the low 16 bits of the chosen data register and writes the result back. The instruction then falls through if the new low word is 0xFFFF, and branches otherwise.

Each instruction ends with a one-cycle done strobe. The strobe comes with the next PC, an optional register write, and the two error flags.

Top module: `cp_dbranch_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, done, cir_wr_en, cir_rd_en, rf_wr_en, timeout_err and proto_err are all low.
- R2: A start accepted while idle produces cir_wr_en in the next cycle, carrying the selector word captured at start. cir_rd_en follows in the cycle after that.
- R3: Response codes are 4'h1 busy, 4'h2 true and 4'h3 false. While the response is busy, the controller reads again every cycle. With timeout_limit N, up to N busy responses are tolerated before a final response.
- R4: A true response ends the instruction with rf_wr_en low and next_pc = scan_pc + 2.
- R5: A false response writes register rf_wr_idx = reg_sel. The write keeps bits 31:16 and sets bits 15:0 to the old low word minus one, modulo 2^16.
- R6: After a false response, a new low word of 0xFFFF gives next_pc = scan_pc + 2. Any other value gives next_pc = scan_pc + the sign-extended displacement.
- R7: The displacement is treated as two's complement, so a displacement with bit 15 set moves the target below the scan PC.
- R8: If the (N+1)-th consecutive response is busy, the instruction aborts. Done is raised with timeout_err, rf_wr_en stays low, and next_pc = scan_pc + 2.
- R9: A response code other than 4'h1, 4'h2 or 4'h3 aborts the instruction. Done is raised with proto_err, rf_wr_en stays low, and next_pc = scan_pc + 2.
- R10: Done lasts exactly one cycle. A start seen while an instruction is in progress is ignored, so each instruction makes exactly one condition write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| reg_sel | input | 3 | Data-register index from bits 2–0 of the operation word |
| sel_word | input | 16 | Condition-selector word |
| disp_word | input | 16 | Branch displacement, two's complement |
| scan_pc | input | 32 | Address of the displacement word |
| timeout_limit | input | 8 | Number of busy responses tolerated |
| cir_wr_en | output | 1 | Write strobe to the condition register |
| cir_wr_data | output | 16 | Selector written to the condition register |
| cir_rd_en | output | 1 | Read strobe of the response register |
| resp_code | input | 4 | Response register contents, sampled while cir_rd_en is high |
| rf_rd_idx | output | 3 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data |
| rf_wr_en | output | 1 | Register-file write enable, valid with done |
| rf_wr_idx | output | 3 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| next_pc | output | 32 | Address of the next instruction, valid with done |
| done | output | 1 | One-cycle completion strobe |
| timeout_err | output | 1 | Abort after too many busy responses, valid with done |
| proto_err | output | 1 | Abort on an unknown response code, valid with done |

## Verification
The hardest conditions to reach are the edges of the busy-retry window and the counter wrap from 0x0000 to 0xFFFF. A wrong window bound passes whenever the busy count is far from the limit. A wrong wrap test passes whenever the low word is not zero.

The bench plays the coprocessor and sets how many busy responses come before the final code. It sweeps every limit from 0 to 3, with exactly the limit and with one busy response more than the limit. It also sweeps every register index across low words of 0x0000, 0x0001, 0x7FFF, 0x8000 and 0xFFFF, using both positive and negative displacements. During each instruction it holds start high with a different selector, so a stray second acceptance would show up as an extra condition write.

// File: rtl/cpdb_pkg.sv
package cpdb_pkg;

    localparam int RESP_W     = 4;
    localparam int INSTR_STEP = 2;

    localparam logic [RESP_W-1:0] CODE_BUSY  = 4'h1;
    localparam logic [RESP_W-1:0] CODE_TRUE  = 4'h2;
    localparam logic [RESP_W-1:0] CODE_FALSE = 4'h3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE_COND,
        ST_READ_RESP,
        ST_DECREMENT,
        ST_RESOLVE,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        RK_BUSY,
        RK_TRUE,
        RK_FALSE,
        RK_BAD
    } resp_kind_t;

    typedef struct packed {
        logic cond_false;
        logic timed_out;
        logic bad_code;
    } outcome_t;

    function automatic resp_kind_t classify(input logic [RESP_W-1:0] code);
        resp_kind_t k;
        case (code)
            CODE_BUSY:  k = RK_BUSY;
            CODE_TRUE:  k = RK_TRUE;
            CODE_FALSE: k = RK_FALSE;
            default:    k = RK_BAD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cpdb_dec.sv
module cpdb_dec #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [DATA_W-1:0] in_word,
    output logic [DATA_W-1:0] out_word,
    output logic              expired
);
    logic [CNT_W-1:0] low_next;

    assign low_next = in_word[CNT_W-1:0] - CNT_W'(1);
    assign expired  = &low_next;

    generate
        if (DATA_W > CNT_W) begin : g_split
            assign out_word = {in_word[DATA_W-1:CNT_W], low_next};
        end else begin : g_full
            assign out_word = low_next;
        end
    endgenerate

endmodule

// File: rtl/cpdb_target.sv
module cpdb_target #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int STEP   = 2
) (
    input  logic [ADDR_W-1:0] scan_pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              take,
    output logic [ADDR_W-1:0] next_pc
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] branch_pc;
    logic [ADDR_W-1:0] fall_pc;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_noext
            assign disp_ext = disp[ADDR_W-1:0];
        end
    endgenerate

    assign branch_pc = scan_pc + disp_ext;
    assign fall_pc   = scan_pc + ADDR_W'(STEP);
    assign next_pc   = take ? branch_pc : fall_pc;

endmodule

// File: rtl/cpdb_seq.sv
module cpdb_seq
    import cpdb_pkg::*;
#(
    parameter int TO_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TO_W-1:0]   timeout_limit,
    input  logic [RESP_W-1:0] resp_code,
    output logic              accept,
    output logic              cir_wr_en,
    output logic              cir_rd_en,
    output logic              dec_en,
    output logic              resolve_en,
    output logic              done,
    output outcome_t          outcome
);
    seq_state_t      state;
    logic [TO_W-1:0] wait_cnt;
    logic [TO_W-1:0] limit_q;
    resp_kind_t      kind;

    assign kind = classify(resp_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            limit_q  <= '0;
            outcome  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_WRITE_COND;
                        wait_cnt <= '0;
                        limit_q  <= timeout_limit;
                        outcome  <= '0;
                    end
                end
                ST_WRITE_COND: state <= ST_READ_RESP;
                ST_READ_RESP: begin
                    case (kind)
                        RK_TRUE: state <= ST_RESOLVE;
                        RK_FALSE: begin
                            outcome.cond_false <= 1'b1;
                            state              <= ST_DECREMENT;
                        end
                        RK_BUSY: begin
                            if (wait_cnt == limit_q) begin
                                outcome.timed_out <= 1'b1;
                                state             <= ST_RESOLVE;
                            end else begin
                                wait_cnt <= wait_cnt + TO_W'(1);
                            end
                        end
                        default: begin
                            outcome.bad_code <= 1'b1;
                            state            <= ST_RESOLVE;
                        end
                    endcase
                end
                ST_DECREMENT: state <= ST_RESOLVE;
                ST_RESOLVE:   state <= ST_DONE;
                ST_DONE:      state <= ST_IDLE;
                default:      state <= ST_IDLE;
            endcase
        end
    end

    assign accept     = (state == ST_IDLE) && start;
    assign cir_wr_en  = (state == ST_WRITE_COND);
    assign cir_rd_en  = (state == ST_READ_RESP);
    assign dec_en     = (state == ST_DECREMENT);
    assign resolve_en = (state == ST_RESOLVE);
    assign done       = (state == ST_DONE);

    // R3
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= limit_q);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    write_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> cir_wr_en);

    // R2
    read_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        cir_wr_en |=> cir_rd_en);

    // R8
    abort_kind_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(outcome) <= 1);

endmodule

// File: rtl/cp_dbranch_ctrl.sv
module cp_dbranch_ctrl
    import cpdb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int SEL_W  = 16,
    parameter int IDX_W  = 3,
    parameter int TO_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  reg_sel,
    input  logic [SEL_W-1:0]  sel_word,
    input  logic [DISP_W-1:0] disp_word,
    input  logic [ADDR_W-1:0] scan_pc,
    input  logic [TO_W-1:0]   timeout_limit,
    output logic              cir_wr_en,
    output logic [SEL_W-1:0]  cir_wr_data,
    output logic              cir_rd_en,
    input  logic [RESP_W-1:0] resp_code,
    output logic [IDX_W-1:0]  rf_rd_idx,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic [ADDR_W-1:0] next_pc,
    output logic              done,
    output logic              timeout_err,
    output logic              proto_err
);
    logic              accept;
    logic              dec_en;
    logic              resolve_en;
    outcome_t          outcome;

    logic [IDX_W-1:0]  idx_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DISP_W-1:0] disp_q;
    logic [ADDR_W-1:0] scan_q;
    logic [DATA_W-1:0] wr_data_q;
    logic              expired_q;
    logic [ADDR_W-1:0] next_pc_q;

    logic [DATA_W-1:0] dec_word;
    logic              dec_expired;
    logic              take;
    logic [ADDR_W-1:0] target_pc;

    cpdb_seq #(.TO_W(TO_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .timeout_limit (timeout_limit),
        .resp_code     (resp_code),
        .accept        (accept),
        .cir_wr_en     (cir_wr_en),
        .cir_rd_en     (cir_rd_en),
        .dec_en        (dec_en),
        .resolve_en    (resolve_en),
        .done          (done),
        .outcome       (outcome)
    );

    cpdb_dec #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
        .in_word  (rf_rd_data),
        .out_word (dec_word),
        .expired  (dec_expired)
    );

    assign take = outcome.cond_false && !expired_q;

    cpdb_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .STEP(INSTR_STEP)) u_target (
        .scan_pc (scan_q),
        .disp    (disp_q),
        .take    (take),
        .next_pc (target_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            sel_q     <= '0;
            disp_q    <= '0;
            scan_q    <= '0;
            wr_data_q <= '0;
            expired_q <= 1'b0;
            next_pc_q <= '0;
        end else begin
            if (accept) begin
                idx_q     <= reg_sel;
                sel_q     <= sel_word;
                disp_q    <= disp_word;
                scan_q    <= scan_pc;
                expired_q <= 1'b0;
            end
            if (dec_en) begin
                wr_data_q <= dec_word;
                expired_q <= dec_expired;
            end
            if (resolve_en) begin
                next_pc_q <= target_pc;
            end
        end
    end

    assign cir_wr_data = sel_q;
    assign rf_rd_idx   = idx_q;
    assign rf_wr_idx   = idx_q;
    assign rf_wr_data  = wr_data_q;
    assign rf_wr_en    = done && outcome.cond_false;
    assign next_pc     = next_pc_q;
    assign timeout_err = done && outcome.timed_out;
    assign proto_err   = done && outcome.bad_code;

    // R5
    generate
        if (DATA_W > CNT_W) begin : g_upper_chk
            upper_kept_chk: assert property (@(posedge clk) disable iff (rst)
                rf_wr_en |-> rf_wr_data[DATA_W-1:CNT_W] == rf_rd_data[DATA_W-1:CNT_W]);
        end
    endgenerate

    // R9
    no_write_on_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (timeout_err || proto_err) |-> !rf_wr_en);

    // R4
    fall_through_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !rf_wr_en) |-> next_pc == scan_q + ADDR_W'(INSTR_STEP));

    // R8
    errors_only_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        (timeout_err || proto_err) |-> done);

endmodule

// File: tb/cp_dbranch_ctrl_test.sv
`timescale 1ns/1ps
module cp_dbranch_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] sel_word = '0;
    logic [15:0] disp_word = '0;
    logic [31:0] scan_pc = '0;
    logic [7:0]  timeout_limit = '0;
    logic        cir_wr_en;
    logic [15:0] cir_wr_data;
    logic        cir_rd_en;
    logic [3:0]  resp_code = '0;
    logic [2:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_idx;
    logic [31:0] rf_wr_data;
    logic [31:0] next_pc;
    logic        done;
    logic        timeout_err;
    logic        proto_err;

    logic [31:0] rf [8];
    assign rf_rd_data = rf[rf_rd_idx];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cp_dbranch_ctrl uut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .reg_sel       (reg_sel),
        .sel_word      (sel_word),
        .disp_word     (disp_word),
        .scan_pc       (scan_pc),
        .timeout_limit (timeout_limit),
        .cir_wr_en     (cir_wr_en),
        .cir_wr_data   (cir_wr_data),
        .cir_rd_en     (cir_rd_en),
        .resp_code     (resp_code),
        .rf_rd_idx     (rf_rd_idx),
        .rf_rd_data    (rf_rd_data),
        .rf_wr_en      (rf_wr_en),
        .rf_wr_idx     (rf_wr_idx),
        .rf_wr_data    (rf_wr_data),
        .next_pc       (next_pc),
        .done          (done),
        .timeout_err   (timeout_err),
        .proto_err     (proto_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_case(input int idx, input logic [15:0] low, input logic [15:0] up,
                            input logic [15:0] disp, input logic [31:0] spc, input int nbusy,
                            input logic [3:0] fin, input int lim);
        int          reads;
        int          wrs;
        int          guard;
        bit          first;
        bit          exp_wr;
        bit          exp_to;
        bit          exp_pr;
        logic [15:0] nl;
        logic [15:0] sel;
        logic [31:0] exp_pc;
        reads = 0;
        wrs = 0;
        guard = 0;
        first = 1'b1;
        sel = 16'hA500 ^ 16'(idx * 37) ^ low;
        rf[idx] = {up, low};
        @(negedge clk);
        reg_sel = 3'(idx);
        sel_word = sel;
        disp_word = disp;
        scan_pc = spc;
        timeout_limit = 8'(lim);
        start = 1'b1;
        @(negedge clk);
        sel_word = ~sel;
        reg_sel = 3'(idx + 1);
        check(cir_wr_en == 1'b1, "R2 cond write strobe", 64'(cir_wr_en), 64'd1);
        check(cir_wr_data == sel, "R2 cond write data", 64'(cir_wr_data), 64'(sel));
        wrs = 1;
        while (guard < 200) begin
            @(negedge clk);
            guard++;
            if (first) begin
                check(cir_rd_en == 1'b1, "R2 read after write", 64'(cir_rd_en), 64'd1);
                first = 1'b0;
            end
            if (cir_wr_en) wrs++;
            if (done) break;
            if (cir_rd_en) begin
                resp_code = (reads < nbusy) ? 4'h1 : fin;
                reads++;
            end
        end
        start = 1'b0;
        exp_to = (nbusy > lim);
        exp_wr = !exp_to && (fin == 4'h3);
        exp_pr = !exp_to && (fin != 4'h1) && (fin != 4'h2) && (fin != 4'h3);
        nl = low - 16'd1;
        exp_pc = spc + 32'd2;
        if (exp_wr && nl != 16'hFFFF) exp_pc = spc + {{16{disp[15]}}, disp};
        check(done == 1'b1, "R10 done reached", 64'(done), 64'd1);
        check(reads == (exp_to ? lim + 1 : nbusy + 1), "R3 read count", 64'(reads),
              64'(exp_to ? lim + 1 : nbusy + 1));
        check(wrs == 1, "R10 single cond write", 64'(wrs), 64'd1);
        check(timeout_err == exp_to, "R8 timeout flag", 64'(timeout_err), 64'(exp_to));
        check(proto_err == exp_pr, "R9 protocol flag", 64'(proto_err), 64'(exp_pr));
        if (exp_to || exp_pr || fin == 4'h2)
            check(rf_wr_en == 1'b0, "R4 no write", 64'(rf_wr_en), 64'd0);
        else
            check(rf_wr_en == 1'b1, "R5 write enable", 64'(rf_wr_en), 64'd1);
        if (exp_wr) begin
            check(rf_wr_idx == 3'(idx), "R5 write index", 64'(rf_wr_idx), 64'(idx));
            check(rf_wr_data == {up, nl}, "R5 write data", 64'(rf_wr_data), 64'({up, nl}));
        end
        if (exp_wr && disp[15] && nl != 16'hFFFF)
            check(next_pc == exp_pc, "R7 negative target", 64'(next_pc), 64'(exp_pc));
        else if (exp_wr)
            check(next_pc == exp_pc, "R6 next pc", 64'(next_pc), 64'(exp_pc));
        else
            check(next_pc == exp_pc, "R4 fall-through pc", 64'(next_pc), 64'(exp_pc));
        if (rf_wr_en) rf[rf_wr_idx] = rf_wr_data;
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lows [6];
        lows[0] = 16'h0000; lows[1] = 16'h0001; lows[2] = 16'h8000;
        lows[3] = 16'hFFFF; lows[4] = 16'h7FFF; lows[5] = 16'h1234;
        for (int i = 0; i < 8; i++) rf[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({done, cir_wr_en, cir_rd_en, rf_wr_en, timeout_err, proto_err} == 6'b0,
              "R1 reset outputs", 64'({done, cir_wr_en, cir_rd_en, rf_wr_en, timeout_err, proto_err}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check({done, cir_wr_en, cir_rd_en, rf_wr_en, timeout_err, proto_err} == 6'b0,
              "R1 outputs after reset", 64'({done, cir_wr_en, cir_rd_en, rf_wr_en, timeout_err, proto_err}), 64'd0);

        // R5 R6 R7: false responses across registers, low words, displacements
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 6; k++) begin
                run_case(r, lows[k], 16'(16'hBEEF ^ 16'(r << 4)),
                         (k % 2 == 0) ? 16'h0040 : 16'hFF80,
                         32'h0001_0000 + 32'(r * 256 + k * 8), (r + k) % 3, 4'h3, 3);
            end
        end

        // R4: true responses leave registers alone
        for (int r = 0; r < 8; r++) begin
            run_case(r, 16'(r), 16'h5555, 16'h0100, 32'h0000_2000 + 32'(r * 4), r % 4, 4'h2, 3);
        end

        // R3 R8: retry window edges
        for (int lim = 0; lim < 4; lim++) begin
            run_case(lim, 16'h0010, 16'h0F0F, 16'hFFF0, 32'h8000_0000, lim, 4'h3, lim);
            run_case(lim, 16'h0010, 16'h0F0F, 16'hFFF0, 32'h8000_0000, lim + 1, 4'h3, lim);
        end

        // R9: unknown response codes
        for (int c = 0; c < 16; c++) begin
            if (c != 1 && c != 2 && c != 3)
                run_case(c % 8, 16'h0005, 16'h1111, 16'h0020, 32'h0000_4000, c % 2, 4'(c), 2);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule